// File: doc/BRIEF.md
# Lazy Word-Initializing Payload Buffer Port

This block fronts a word-organised payload RAM whose bytes each carry an even parity bit. The writer is a serial-side agent that normally stores one byte at a time, and its clock is too intermittent to sweep the whole RAM after reset. Instead, the block keeps one "initialized" flag per word. The first write that reaches a word always stores all four byte lanes. Lanes outside the requested mask are filled with zero and given correct parity. Later writes to the same word touch only the lanes they ask for.

The read port is registered and has one cycle of latency. It returns the stored word and reports a parity mismatch in any lane. A word that has never been written reads as zero without an error, so the system side can never see a word whose parity was never set up.

Top module: `wib_top`

## Requirements
- R1: An active-low asynchronous reset clears every word's initialized flag; after reset, every word reads as zero with no parity error, and rdValid, rdData and rdParErr are low.
- R2: A write whose mask is not 4'b1111, to an uninitialized word, stores the masked lanes from wrData and zero in every other lane. Lane n is wrData[8n+7:8n].
- R3: A write to an initialized word changes only the lanes whose mask bit is set and leaves the other lanes unchanged.
- R4: A full-mask write (4'b1111) to an uninitialized word stores wrData unchanged and marks the word initialized.
- R5: rdValid is high in exactly the cycle after a cycle with rdEn high, and rdData and rdParErr are valid in that same cycle.
- R6: A read of an uninitialized word returns zero data with rdParErr low.
- R7: Every lane is stored with even parity computed at write time, so a read of any written word reports rdParErr low.
- R8: A zero-mask write to an uninitialized word sets the whole word to zero and marks it initialized. A zero-mask write to an initialized word changes nothing.
- R9: When a read and a write address the same word in the same cycle, the read returns the contents from before that write, and the word's state from before that write decides whether it reads as zero.
- R10: A write changes neither the data nor the initialized flag of any other word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write request |
| wrAddr | input | $clog2(DEPTH) | Word address of the write |
| wrData | input | 32 | Write data, lane n in bits 8n+7:8n |
| wrMask | input | 4 | Per-lane write enable, bit n selects lane n |
| rdEn | input | 1 | Read request |
| rdAddr | input | $clog2(DEPTH) | Word address of the read |
| rdData | output | 32 | Read data, one cycle after rdEn |
| rdValid | output | 1 | High when rdData and rdParErr hold a result |
| rdParErr | output | 1 | Parity mismatch in any lane of the word read |

## Verification
A read and a write can hit the same word in the same clock edge. In that case the read sees the old contents, and the old initialized flag decides whether it returns zero. The bench provokes this twice. The first case writes one lane of an initialized word while reading it. The second case writes a full word into an uninitialized location while reading it. Each case expects the pre-write value on the read, and a second read then confirms that the write took effect.

// File: rtl/wib_pkg.sv
package wib_pkg;

  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic             wrGo;      // commit a write this cycle
    logic [LANES-1:0] byteEn;    // lanes actually written
    logic [LANES-1:0] zeroFill;  // lanes written with zero instead of data
    logic             rdGo;      // capture a read this cycle
    logic             rdInit;    // word being read has been initialized
  } wib_strobe_t;

  function automatic logic evenPar(input logic [LANE_W-1:0] b);
    return ^b;
  endfunction

endpackage

// File: rtl/wib_ctrl.sv
module wib_ctrl
  import wib_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [LANES-1:0] wrMask,
  input  logic             rdEn,
  input  logic [AW-1:0]    rdAddr,
  output wib_strobe_t      stb
);

  logic [DEPTH-1:0] initQ;
  logic             wrWordInit;

  assign wrWordInit = initQ[wrAddr];

  // One flag per word; set by any write, cleared only by reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initQ <= '0;
    end else if (wrEn) begin
      initQ[wrAddr] <= 1'b1;
    end
  end

  always_comb begin
    stb          = '0;
    stb.wrGo     = wrEn;
    stb.rdGo     = rdEn;
    stb.rdInit   = initQ[rdAddr];
    if (wrWordInit) begin
      stb.byteEn   = wrMask;
      stb.zeroFill = '0;
    end else begin
      // First touch: widen to every lane, zero the unrequested ones.
      stb.byteEn   = '1;
      stb.zeroFill = ~wrMask;
    end
  end

endmodule

// File: rtl/wib_dpath.sv
module wib_dpath
  import wib_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  wib_strobe_t       stb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [AW-1:0]     rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic              rdParErr
);

  logic [WORD_W-1:0] rdWord;
  logic [LANES-1:0]  laneErr;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W:0]   laneMem [DEPTH];
    logic [LANE_W-1:0] wrByte;
    logic [LANE_W:0]   rdCell;

    assign wrByte = stb.zeroFill[g] ? '0 : wrData[g*LANE_W +: LANE_W];

    always_ff @(posedge clk) begin
      if (stb.wrGo && stb.byteEn[g]) begin
        laneMem[wrAddr] <= {evenPar(wrByte), wrByte};
      end
    end

    assign rdCell                      = laneMem[rdAddr];
    assign rdWord[g*LANE_W +: LANE_W]  = rdCell[LANE_W-1:0];
    assign laneErr[g]                  = ^rdCell;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData   <= '0;
      rdValid  <= 1'b0;
      rdParErr <= 1'b0;
    end else begin
      rdValid <= stb.rdGo;
      if (stb.rdGo) begin
        rdData   <= stb.rdInit ? rdWord : '0;
        rdParErr <= stb.rdInit & (|laneErr);
      end
    end
  end

endmodule

// File: rtl/wib_top.sv
module wib_top
  import wib_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [$clog2(DEPTH)-1:0]   wrAddr,
  input  logic [31:0]                wrData,
  input  logic [3:0]                 wrMask,
  input  logic                       rdEn,
  input  logic [$clog2(DEPTH)-1:0]   rdAddr,
  output logic [31:0]                rdData,
  output logic                       rdValid,
  output logic                       rdParErr
);

  wib_strobe_t stb;

  wib_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrMask (wrMask),
    .rdEn   (rdEn),
    .rdAddr (rdAddr),
    .stb    (stb)
  );

  wib_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .rdValid  (rdValid),
    .rdParErr (rdParErr)
  );

endmodule

// File: rtl/wib_chk.sv
module wib_chk
  import wib_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrEn,
  input logic [AW-1:0] wrAddr,
  input logic [3:0]    wrMask,
  input logic          rdEn,
  input logic [AW-1:0] rdAddr,
  input logic [31:0]   rdData,
  input logic          rdValid,
  input logic          rdParErr,
  input wib_strobe_t   stb
);

  // Independent shadow of which words have been written.
  logic [DEPTH-1:0] shadowQ;
  logic             rdWasInitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowQ    <= '0;
      rdWasInitQ <= 1'b0;
    end else begin
      if (wrEn) shadowQ[wrAddr] <= 1'b1;
      if (rdEn) rdWasInitQ <= shadowQ[rdAddr];
    end
  end

  a_r2_first_write_widened: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrGo && !shadowQ[wrAddr] |-> stb.byteEn == 4'hF && stb.zeroFill == ~wrMask);

  a_r3_later_write_masked: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrGo && shadowQ[wrAddr] |-> stb.byteEn == wrMask && stb.zeroFill == 4'h0);

  a_r5_valid_after_read: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  a_r5_no_valid_without_read: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

  a_r6_uninit_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !rdWasInitQ |-> rdData == 32'h0 && !rdParErr);

  a_r6_init_flag_matches: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdGo |-> stb.rdInit == shadowQ[rdAddr]);

  a_r7_no_parity_error: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !rdParErr);

endmodule

bind wib_top wib_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrMask   (wrMask),
  .rdEn     (rdEn),
  .rdAddr   (rdAddr),
  .rdData   (rdData),
  .rdValid  (rdValid),
  .rdParErr (rdParErr),
  .stb      (stb)
);

// File: tb/sim_wib_top.sv
module sim_wib_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  wrMask = '0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        rdValid;
  logic        rdParErr;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  wib_top #(.DEPTH(256)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrMask(wrMask), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .rdValid(rdValid), .rdParErr(rdParErr)
  );

  // {addr, mask, data, expected read after the write}
  localparam int NV = 10;
  localparam logic [75:0] VEC [NV] = '{
    {8'h10, 4'b0001, 32'hAABBCCDD, 32'h000000DD},  // R2 first partial write
    {8'h10, 4'b0100, 32'h11223344, 32'h002200DD},  // R3 later partial write
    {8'h20, 4'b1111, 32'hDEADBEEF, 32'hDEADBEEF},  // R4 full first write
    {8'h20, 4'b0010, 32'h0000A500, 32'hDEADA5EF},  // R3
    {8'h30, 4'b1000, 32'h7F000000, 32'h7F000000},  // R2
    {8'h30, 4'b0000, 32'hFFFFFFFF, 32'h7F000000},  // R8 zero mask, initialized
    {8'h40, 4'b0000, 32'hFFFFFFFF, 32'h00000000},  // R8 zero mask, uninitialized
    {8'hFF, 4'b0110, 32'h12345678, 32'h00345600},  // R2 top word
    {8'h00, 4'b1001, 32'h89ABCDEF, 32'h890000EF},  // R2 bottom word
    {8'h00, 4'b0110, 32'h01020304, 32'h890203EF}   // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [3:0] m, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrMask = m; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Read; result sampled on the following falling edge (R5).
  task automatic doRead(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    check({req, " rdValid"}, {31'b0, rdValid}, 32'h1);
    check({req, " rdData"}, rdData, exp);
    check({req, " rdParErr"}, {31'b0, rdParErr}, 32'h0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: outputs quiet in reset
    check("R1 rdValid in reset", {31'b0, rdValid}, 32'h0);
    check("R1 rdData in reset", rdData, 32'h0);
    rstN = 1'b1;
    doRead("R1 R6 read after reset", 8'h50, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [75:0] v;
      v = VEC[i];
      doWrite(v[75:68], v[67:64], v[63:32]);
      doRead($sformatf("vector %0d", i), v[75:68], v[31:0]);
    end

    // R10: neighbours untouched
    doRead("R10 neighbour 0x11", 8'h11, 32'h0);
    doRead("R10 neighbour 0x0F", 8'h0F, 32'h0);
    doRead("R10 neighbour 0x01", 8'h01, 32'h0);

    // R5: no read means no rdValid on the next cycle
    @(negedge clk);
    @(negedge clk);
    check("R5 idle rdValid", {31'b0, rdValid}, 32'h0);

    // R9: same-cycle read and write of an initialized word
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 8'h20; wrMask = 4'b0001; wrData = 32'h00000011;
    rdEn = 1'b1; rdAddr = 8'h20;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R9 collide old data", rdData, 32'hDEADA5EF);
    doRead("R9 after collide", 8'h20, 32'hDEADA511);

    // R9: same-cycle on an uninitialized word reads zero
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 8'h60; wrMask = 4'b1111; wrData = 32'hCAFEF00D;
    rdEn = 1'b1; rdAddr = 8'h60;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R9 collide uninit", rdData, 32'h0);
    check("R9 collide uninit parErr", {31'b0, rdParErr}, 32'h0);
    doRead("R4 R9 after collide uninit", 8'h60, 32'hCAFEF00D);

    // R1: reset in mid-run forgets every word
    doReset();
    check("R1 rdValid after reset", {31'b0, rdValid}, 32'h0);
    doRead("R1 word 0x20 after reset", 8'h20, 32'h0);
    doRead("R1 word 0x00 after reset", 8'h00, 32'h0);
    // R2 after reset: stale lanes must be zero-filled again
    doWrite(8'h20, 4'b0100, 32'h00990000);
    doRead("R2 refill after reset", 8'h20, 32'h00990000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule